// File: doc/BRIEF.md
# Dual-Clock Width-Matching FIFO

This block is a first-in first-out buffer whose storage is built from 9-bit entries, with a write port and a read port that each carry either 9-bit or 18-bit words. The two widths are picked separately, so a narrow producer can feed a wide consumer or the other way round. A wide word takes up two adjacent 9-bit entries. A word-order select chooses whether the upper half (`[17:9]`) or the lower half (`[8:0]`) of an 18-bit word belongs to the earlier entry. The write side and the read side each run on their own clock. Pointers cross between the two clocks in Gray code.

Both ports are valid/ready streams. A write transfers on a rising write-clock edge where `wr_valid` and `wr_ready` are both high. A read transfers on a rising read-clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and the consumer holds `rd_ready` low, the word on offer stays put. The producer may hold `wr_valid` high while `wr_ready` is low, and nothing is stored. The width and order pins are sampled only while master reset is held low. Partial reset empties the buffer and keeps the sampled settings.

Top module: `busmatch_fifo`

## Requirements
- R1: With both ports narrow, 9-bit words come out in write order. The word-order select has no effect. `wr_data[17:9]` is ignored, and `rd_data[17:9]` reads zero.
- R2: `cfg_wr_wide`, `cfg_rd_wide` and `cfg_big_end` are sampled only while `mrst_n` is low. Changing them while `mrst_n` is high has no effect on the data path.
- R3: With a wide write port and a narrow read port, each 18-bit word is read as two successive 9-bit words in `rd_data[8:0]`. When `cfg_big_end`=1, `wr_data[17:9]` comes first. When `cfg_big_end`=0, `wr_data[8:0]` comes first.
- R4: With a narrow write port and a wide read port, two successive 9-bit writes form one 18-bit read. When `cfg_big_end`=1, the earlier write lands in `rd_data[17:9]`. When `cfg_big_end`=0, it lands in `rd_data[8:0]`.
- R5: With both ports wide, every 18-bit word is read back unchanged, whatever the value of `cfg_big_end`.
- R6: A wide read is offered only when two entries are stored. A single leftover half stays stored, with `rd_valid` low, until its partner is written.
- R7: While `prst_n` is low, `rd_valid` is low and `wr_ready` is high. Stored data is discarded, and the sampled width and order settings are kept.
- R8: Master reset empties the buffer, so `rd_valid` goes low and `wr_ready` goes high, and it samples a fresh configuration.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. A write attempted while `wr_ready` is low stores nothing.
- R10: The buffer holds 2^ADDR_BITS entries, which is 16 narrow words or 8 wide words at the default setting. `wr_ready` goes low once a further write would not fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; samples configuration |
| prst_n | input | 1 | Partial reset, active low; clears pointers only |
| cfg_wr_wide | input | 1 | 1: write port is 18 bits, 0: 9 bits |
| cfg_rd_wide | input | 1 | 1: read port is 18 bits, 0: 9 bits |
| cfg_big_end | input | 1 | 1: upper half is the earlier entry, 0: lower half |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Room for one write word |
| wr_data | input | 2*HALF_W | Write word (narrow mode uses bits [8:0]) |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 2*HALF_W | Read word (narrow mode fills bits [8:0]) |

## Verification
Two situations are the hardest to reach from the ports. The first is a lone half-word stranded in narrow-to-wide mode. The second is a partial reset that lands between the two halves of a wide word. For the first, the stimulus writes an odd number of narrow words and drains the complete pairs. It then waits long enough for the pointers to cross clocks and shows that nothing is offered until the partner word is written. For the second, it reads one half of a wide word, pulses the partial reset with the configuration pins deliberately changed, and confirms that the next word splits in the order sampled at master reset. The two clocks run at unrelated periods, so the pointer crossings are exercised at shifting phase offsets.

// File: rtl/bmf_pkg.sv
`timescale 1ns/1ps
package bmf_pkg;
  // Port widths and word order, held in each clock domain.
  typedef struct packed {
    logic wr_wide;
    logic rd_wide;
    logic big_end;
  } cfg_t;
endpackage

// File: rtl/bmf_cfg_latch.sv
`timescale 1ns/1ps
module bmf_cfg_latch
  import bmf_pkg::*;
(
  input  logic clk,
  input  logic mrst_n,
  input  cfg_t pins,
  output cfg_t cfg
);
  // Sampled on every edge while master reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!mrst_n) cfg <= pins;
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(cfg)); // R2
endmodule

// File: rtl/bmf_ptr_xfer.sv
`timescale 1ns/1ps
module bmf_ptr_xfer #(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_ptr,
  input  logic          src_wide,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  input  logic          dst_src_wide,
  output logic [PW-1:0] dst_ptr
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] half_b, half_g, tx_d, tx_q, rx, rx_half;
  logic [STAGES-1:0][PW-1:0] sync_q;

  // A wide side always steps by two: code the pair index so one bit flips.
  always_comb begin
    half_b = src_ptr >> 1;
    half_g = to_gray(half_b);
    tx_d   = src_wide ? {half_g[PW-2:0], 1'b0} : to_gray(src_ptr);
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tx_q <= '0;
    else            tx_q <= tx_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= tx_q;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    rx      = sync_q[STAGES-1];
    rx_half = from_gray({1'b0, rx[PW-1:1]});
    dst_ptr = dst_src_wide ? {rx_half[PW-2:0], 1'b0} : from_gray(rx);
  end
endmodule

// File: rtl/bmf_store.sv
`timescale 1ns/1ps
module bmf_store #(
  parameter int HW  = 9,
  parameter int RAW = 3
) (
  input  logic                wr_clk,
  input  logic [1:0]          we,
  input  logic [RAW-1:0]      waddr,
  input  logic [1:0][HW-1:0]  wdata,
  input  logic [RAW-1:0]      raddr,
  output logic [1:0][HW-1:0]  rdata
);
  localparam int ROWS = 1 << RAW;

  // Even entries in bank 0, odd entries in bank 1: a pair shares one row.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [HW-1:0] mem [ROWS];
    always_ff @(posedge wr_clk) begin
      if (we[b]) mem[waddr] <= wdata[b];
    end
    assign rdata[b] = mem[raddr];
  end
endmodule

// File: rtl/bmf_wr_ctl.sv
`timescale 1ns/1ps
module bmf_wr_ctl
  import bmf_pkg::*;
#(
  parameter int HW = 9,
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [2*HW-1:0]    wr_data,
  input  logic [AW:0]        rptr_s,
  output logic [AW:0]        wptr,
  output logic [1:0]         we,
  output logic [AW-2:0]      waddr,
  output logic [1:0][HW-1:0] wdata
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] used;
  logic          fire;
  logic [HW-1:0] hi, lo;

  always_comb begin
    used     = wptr - rptr_s;
    wr_ready = cfg.wr_wide ? (used <= PW'(DEPTH - 2)) : (used <= PW'(DEPTH - 1));
    fire     = wr_valid && wr_ready;
    hi       = wr_data[2*HW-1:HW];
    lo       = wr_data[HW-1:0];
    waddr    = wptr[AW-1:1];
    if (cfg.wr_wide) begin
      we       = {fire, fire};
      wdata[0] = cfg.big_end ? hi : lo;
      wdata[1] = cfg.big_end ? lo : hi;
    end else begin
      we       = {fire & wptr[0], fire & ~wptr[0]};
      wdata[0] = lo;
      wdata[1] = lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wptr <= '0;
    else if (fire) wptr <= wptr + (cfg.wr_wide ? PW'(2) : PW'(1));
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH)); // R10
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wptr == $past(wptr))); // R9
endmodule

// File: rtl/bmf_rd_ctl.sv
`timescale 1ns/1ps
module bmf_rd_ctl
  import bmf_pkg::*;
#(
  parameter int HW = 9,
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [2*HW-1:0]    rd_data,
  input  logic [AW:0]        wptr_s,
  output logic [AW:0]        rptr,
  output logic [AW-2:0]      raddr,
  input  logic [1:0][HW-1:0] rdata
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] avail;
  logic          fire;

  always_comb begin
    avail    = wptr_s - rptr;
    rd_valid = cfg.rd_wide ? (avail >= PW'(2)) : (avail >= PW'(1));
    fire     = rd_valid && rd_ready;
    raddr    = rptr[AW-1:1];
    if (cfg.rd_wide)
      rd_data = cfg.big_end ? {rdata[0], rdata[1]} : {rdata[1], rdata[0]};
    else
      rd_data = {{HW{1'b0}}, (rptr[0] ? rdata[1] : rdata[0])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rptr <= '0;
    else if (fire) rptr <= rptr + (cfg.rd_wide ? PW'(2) : PW'(1));
  end

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= PW'(DEPTH)); // R6
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
endmodule

// File: rtl/busmatch_fifo.sv
`timescale 1ns/1ps
module busmatch_fifo
  import bmf_pkg::*;
#(
  parameter int HALF_W      = 9,
  parameter int ADDR_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                wr_clk,
  input  logic                rd_clk,
  input  logic                mrst_n,
  input  logic                prst_n,
  input  logic                cfg_wr_wide,
  input  logic                cfg_rd_wide,
  input  logic                cfg_big_end,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [2*HALF_W-1:0] wr_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [2*HALF_W-1:0] rd_data
);
  localparam int PW  = ADDR_BITS + 1;
  localparam int RAW = ADDR_BITS - 1;

  cfg_t pins, wcfg, rcfg;
  logic ptr_rst_n;
  logic [PW-1:0] wptr, rptr, wptr_s, rptr_s;
  logic [1:0] we;
  logic [RAW-1:0] waddr, raddr;
  logic [1:0][HALF_W-1:0] wdata, rdata;

  assign pins.wr_wide = cfg_wr_wide;
  assign pins.rd_wide = cfg_rd_wide;
  assign pins.big_end = cfg_big_end;
  assign ptr_rst_n    = mrst_n & prst_n;

  bmf_cfg_latch u_wcfg (.clk(wr_clk), .mrst_n(mrst_n), .pins(pins), .cfg(wcfg));
  bmf_cfg_latch u_rcfg (.clk(rd_clk), .mrst_n(mrst_n), .pins(pins), .cfg(rcfg));

  bmf_wr_ctl #(.HW(HALF_W), .AW(ADDR_BITS)) u_wr (
    .clk(wr_clk), .rst_n(ptr_rst_n), .cfg(wcfg),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rptr_s(rptr_s), .wptr(wptr), .we(we), .waddr(waddr), .wdata(wdata));

  bmf_rd_ctl #(.HW(HALF_W), .AW(ADDR_BITS)) u_rd (
    .clk(rd_clk), .rst_n(ptr_rst_n), .cfg(rcfg),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wptr_s(wptr_s), .rptr(rptr), .raddr(raddr), .rdata(rdata));

  bmf_store #(.HW(HALF_W), .RAW(RAW)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata));

  bmf_ptr_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .src_clk(wr_clk), .src_rst_n(ptr_rst_n), .src_ptr(wptr), .src_wide(wcfg.wr_wide),
    .dst_clk(rd_clk), .dst_rst_n(ptr_rst_n), .dst_src_wide(rcfg.wr_wide), .dst_ptr(wptr_s));

  bmf_ptr_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .src_clk(rd_clk), .src_rst_n(ptr_rst_n), .src_ptr(rptr), .src_wide(rcfg.rd_wide),
    .dst_clk(wr_clk), .dst_rst_n(ptr_rst_n), .dst_src_wide(wcfg.rd_wide), .dst_ptr(rptr_s));

  AST_PRST_RD_EMPTY: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    !prst_n |-> !rd_valid); // R7
  AST_PRST_WR_OPEN: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !prst_n |-> wr_ready); // R7
endmodule

// File: tb/busmatch_fifo_test.sv
`timescale 1ns/1ps
module busmatch_fifo_test;
  localparam int HW = 9;
  localparam int DW = 2 * HW;

  typedef struct packed {
    logic        ww, rw, be;
    logic [2:0]  nw;
    logic [71:0] wd;
    logic [2:0]  nr;
    logic [71:0] rd;
  } vec_t;

  localparam logic [17:0] Z = 18'h0;
  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b1,3'd3,{Z,{9'h0,9'h033},{9'h0,9'h022},{9'h0,9'h011}},
      3'd3,{Z,{9'h0,9'h033},{9'h0,9'h022},{9'h0,9'h011}}},
    '{1'b0,1'b0,1'b0,3'd3,{Z,{9'h0,9'h033},{9'h0,9'h022},{9'h0,9'h011}},
      3'd3,{Z,{9'h0,9'h033},{9'h0,9'h022},{9'h0,9'h011}}},
    '{1'b1,1'b0,1'b1,3'd2,{Z,Z,{9'h1C3,9'h0D4},{9'h1A1,9'h0B2}},
      3'd4,{{9'h0,9'h0D4},{9'h0,9'h1C3},{9'h0,9'h0B2},{9'h0,9'h1A1}}},
    '{1'b1,1'b0,1'b0,3'd2,{Z,Z,{9'h1C3,9'h0D4},{9'h1A1,9'h0B2}},
      3'd4,{{9'h0,9'h1C3},{9'h0,9'h0D4},{9'h0,9'h1A1},{9'h0,9'h0B2}}},
    '{1'b0,1'b1,1'b1,3'd4,{{9'h0,9'h088},{9'h0,9'h077},{9'h0,9'h066},{9'h0,9'h055}},
      3'd2,{Z,Z,{9'h077,9'h088},{9'h055,9'h066}}},
    '{1'b0,1'b1,1'b0,3'd4,{{9'h0,9'h088},{9'h0,9'h077},{9'h0,9'h066},{9'h0,9'h055}},
      3'd2,{Z,Z,{9'h088,9'h077},{9'h066,9'h055}}},
    '{1'b1,1'b1,1'b1,3'd2,{Z,Z,{9'h1FE,9'h001},{9'h123,9'h045}},
      3'd2,{Z,Z,{9'h1FE,9'h001},{9'h123,9'h045}}},
    '{1'b1,1'b1,1'b0,3'd2,{Z,Z,{9'h1FE,9'h001},{9'h123,9'h045}},
      3'd2,{Z,Z,{9'h1FE,9'h001},{9'h123,9'h045}}}
  };

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1;
  logic cfg_wr_wide = 1'b0, cfg_rd_wide = 1'b0, cfg_big_end = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [DW-1:0] rd_data;
  int n_tests = 0, n_fail = 0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  busmatch_fifo #(.HALF_W(HW), .ADDR_BITS(4), .SYNC_STAGES(2)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_wr_wide(cfg_wr_wide), .cfg_rd_wide(cfg_rd_wide), .cfg_big_end(cfg_big_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic master_reset(input bit ww, input bit rw, input bit be);
    wr_valid = 1'b0; rd_ready = 1'b0;
    cfg_wr_wide = ww; cfg_rd_wide = rw; cfg_big_end = be;
    mrst_n = 1'b0;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk) mrst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    int guard = 0;
    @(negedge wr_clk);
    wr_data = d; wr_valid = 1'b1;
    while (!wr_ready && guard < 200) begin @(negedge wr_clk); guard++; end
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(input logic [DW-1:0] exp, input string req);
    int guard = 0;
    @(negedge rd_clk);
    while (!rd_valid && guard < 200) begin @(negedge rd_clk); guard++; end
    chk(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
    if (rd_valid) begin
      rd_ready = 1'b1;
      @(negedge rd_clk);
      rd_ready = 1'b0;
    end
  endtask

  function automatic string mode_req(input logic ww, input logic rw);
    if (!ww && !rw) return "R1 narrow/narrow";
    if (ww && !rw)  return "R3 wide-to-narrow";
    if (!ww && rw)  return "R4 narrow-to-wide";
    return "R5 wide/wide";
  endfunction

  initial begin
    repeat (20000) @(posedge wr_clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R8: state right after master reset
    master_reset(1'b0, 1'b0, 1'b1);
    chk(rd_valid === 1'b0, "R8 rd_valid after reset", DW'(rd_valid), '0);
    chk(wr_ready === 1'b1, "R8 wr_ready after reset", DW'(wr_ready), DW'(1));

    // Table walk: every width pairing in both word orders
    foreach (VECS[v]) begin
      master_reset(VECS[v].ww, VECS[v].rw, VECS[v].be);
      for (int i = 0; i < int'(VECS[v].nw); i++)
        push(VECS[v].wd[i*DW +: DW] | (VECS[v].ww ? DW'(0) : {9'h155, 9'h000}));
      for (int i = 0; i < int'(VECS[v].nr); i++)
        pop(VECS[v].rd[i*DW +: DW], mode_req(VECS[v].ww, VECS[v].rw));
    end

    // R2: pins moved after release must be ignored
    master_reset(1'b0, 1'b0, 1'b1);
    cfg_wr_wide = 1'b1; cfg_rd_wide = 1'b1; cfg_big_end = 1'b0;
    push({9'h1F0, 9'h0AB});
    push({9'h1F0, 9'h0CD});
    pop({9'h0, 9'h0AB}, "R2 pins ignored after release");
    pop({9'h0, 9'h0CD}, "R2 pins ignored after release");

    // R6: lone half stays until its partner arrives
    master_reset(1'b0, 1'b1, 1'b1);
    push({9'h0AA, 9'h101}); push({9'h0AA, 9'h102}); push({9'h0AA, 9'h103});
    pop({9'h101, 9'h102}, "R6 first pair");
    settle();
    chk(rd_valid === 1'b0, "R6 lone half not offered", DW'(rd_valid), '0);
    push({9'h0AA, 9'h104});
    pop({9'h103, 9'h104}, "R6 pair completed");

    // R7: partial reset in the middle of a split word keeps the settings
    master_reset(1'b1, 1'b0, 1'b0);
    push({9'h1AA, 9'h0BB});
    pop({9'h0, 9'h0BB}, "R7 before partial reset");
    cfg_wr_wide = 1'b0; cfg_rd_wide = 1'b1; cfg_big_end = 1'b1;
    @(negedge wr_clk) prst_n = 1'b0;
    repeat (2) @(negedge rd_clk);
    chk(rd_valid === 1'b0, "R7 rd_valid during partial reset", DW'(rd_valid), '0);
    chk(wr_ready === 1'b1, "R7 wr_ready during partial reset", DW'(wr_ready), DW'(1));
    @(negedge wr_clk) prst_n = 1'b1;
    settle();
    chk(rd_valid === 1'b0, "R7 leftover half discarded", DW'(rd_valid), '0);
    push({9'h1CC, 9'h0DD});
    pop({9'h0, 9'h0DD}, "R7 settings kept");
    pop({9'h0, 9'h1CC}, "R7 settings kept");

    // R8: master reset with data inside, new configuration takes hold
    master_reset(1'b0, 1'b0, 1'b0);
    push({9'h0, 9'h0E1}); push({9'h0, 9'h0E2});
    master_reset(1'b1, 1'b0, 1'b1);
    settle();
    chk(rd_valid === 1'b0, "R8 emptied by master reset", DW'(rd_valid), '0);
    chk(wr_ready === 1'b1, "R8 room after master reset", DW'(wr_ready), DW'(1));
    push({9'h1EE, 9'h011});
    pop({9'h0, 9'h1EE}, "R8 new config sampled");
    pop({9'h0, 9'h011}, "R8 new config sampled");

    // R10 and R9: wide capacity, then hold under back-pressure
    master_reset(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) push({9'(9'h100 + k), 9'(k * 3)});
    @(negedge wr_clk);
    chk(wr_ready === 1'b0, "R10 full after 8 wide words", DW'(wr_ready), '0);
    settle();
    repeat (5) @(negedge rd_clk);
    chk(rd_valid === 1'b1 && rd_data === {9'h100, 9'h000},
        "R9 offer held under back-pressure", rd_data, {9'h100, 9'h000});
    for (int k = 0; k < 8; k++) pop({9'(9'h100 + k), 9'(k * 3)}, "R10 wide drain");

    // R10 and R9: narrow capacity, write refused while full
    master_reset(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) push({9'h0, 9'(9'h040 + k)});
    @(negedge wr_clk);
    chk(wr_ready === 1'b0, "R10 full after 16 narrow words", DW'(wr_ready), '0);
    wr_data = {9'h0, 9'h1EE}; wr_valid = 1'b1;
    repeat (3) @(negedge wr_clk);
    wr_valid = 1'b0;
    for (int k = 0; k < 16; k++) pop({9'h0, 9'(9'h040 + k)}, "R10 narrow drain");
    settle();
    chk(rd_valid === 1'b0, "R9 write while full not stored", DW'(rd_valid), '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule